// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the serial front end of a 512-byte non-volatile store. Here the store is an on-chip register array. A host drives chip select, serial clock and serial data. The block decodes a one-byte command, an optional address byte and any data bytes. It then answers with array or status contents on the serial output. Writes to the array are held in a 16-byte page buffer. The array is updated only after a timed internal write cycle, which begins when chip select is released. The cycle length is a count of system clocks.

A write-enable latch, a write-protect input and a two-bit region lock all guard the contents. A status byte gathers the busy flag, the latch, the lock field and a two-bit watchdog interval field. The watchdog field is also driven to a port for a neighbouring supervisor. All serial inputs are resampled in the system clock domain. Each half period of the serial clock must therefore span several system clocks.

Top module: `spi_nvm_ctrl`

## Requirements
- R1: Every byte travels most significant bit first. Serial input is taken on a rising serial clock edge and serial output changes after a falling edge, so the block works in SPI mode 0 and mode 3.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch is visible as status bit 1.
- R3: Command 0x05 returns the status byte: bit 0 busy, bit 1 write-enable latch, bits 3:2 region lock, bits 5:4 watchdog interval, bits 7:6 zero. It repeats the byte for as long as clocking continues.
- R4: Read is 0000_A011 and write is 0000_A010, with opcode bit 3 as address bit 8 and an address byte following. A read streams successive bytes and wraps from 0x1FF to 0x000.
- R5: A write takes data bytes into one 16-byte page. The in-page offset wraps from 15 to 0, and a later byte at the same offset replaces an earlier one.
- R6: A write cycle begins when chip select rises on a byte boundary after at least one data byte. Busy then reads 1 for exactly WRITE_TICKS system clocks, and the array changes at the end of the cycle.
- R7: A write of the array or the status byte starts only if the write-enable latch is 1 and wp_n is 1 when chip select rises. Otherwise nothing changes.
- R8: Region lock 00 protects nothing, 01 protects 0x180-0x1FF, 10 protects 0x100-0x1FF and 11 protects the whole array. A write to a protected page leaves its bytes unchanged.
- R9: Command 0x01 followed by one data byte loads the region lock from data bits 3:2 and the watchdog interval from data bits 5:4. It does so through a write cycle, and wdt_sel follows the new value.
- R10: Reset clears the latch, region lock and watchdog interval and fills the array with 0xFF. The latch clears by itself when any write cycle ends.
- R11: While busy, every command except 0x05 is ignored, and an ignored read returns 0x00.
- R12: If chip select rises part way through a byte, the pending write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins and times the write cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data to the host, 0 when idle |
| wp_n | input | 1 | Active-low write protect |
| wdt_sel | output | 2 | Watchdog interval field for the supervisor |

## Verification
The hardest state to reach from the pins is a command arriving while a write cycle is still running. The host has to finish a page write, lower chip select again and complete a full command byte before the busy window closes. The bench therefore sets a write time long enough to fit a status read and a read command inside it, and issues both at once after a page write that wraps. The partial-byte abort is reached by a bit-level task that clocks only three bits before releasing chip select.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
   // Address width is fixed: opcode bit 3 carries exactly one extra address bit.
   localparam int NVM_ADDR_W = 9;

   localparam logic [7:0] CMD_LATCH_SET = 8'h06;
   localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
   localparam logic [7:0] CMD_STAT_RD   = 8'h05;
   localparam logic [7:0] CMD_STAT_WR   = 8'h01;

   typedef enum logic [2:0] {
      PH_OPCODE, PH_ADDR, PH_RDATA, PH_WDATA, PH_SRDATA, PH_STATUS, PH_IDLE
   } phase_e;

   function automatic logic cmd_is_read(logic [7:0] op);
      return (op[7:4] == 4'h0) && (op[2:0] == 3'b011);
   endfunction

   function automatic logic cmd_is_write(logic [7:0] op);
      return (op[7:4] == 4'h0) && (op[2:0] == 3'b010);
   endfunction

   // top = the two most significant address bits of a page
   function automatic logic region_locked(logic [1:0] top, logic [1:0] lock);
      case (lock)
         2'b00:   return 1'b0;
         2'b01:   return top == 2'b11;
         2'b10:   return top[1];
         default: return 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_rise,
   output logic cs_fall,
   output logic cs_low,
   output logic si_s
);
   localparam int LANES = 3;
   localparam logic [LANES-1:0] IDLE_VAL = 3'b010;  // {si, cs_n, sck}

   logic [LANES-1:0] raw;
   logic [LANES-1:0] synced;
   logic [1:0]       prev_q;

   assign raw = {si, cs_n, sck};

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [LANES-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= IDLE_VAL;
            else        q <= raw;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= IDLE_VAL;
            else        q <= g_stage[s-1].q;
      end
   end

   assign synced = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= IDLE_VAL[1:0];
      else        prev_q <= synced[1:0];

   assign sck_rise = synced[0] & ~prev_q[0];
   assign sck_fall = ~synced[0] & prev_q[0];
   assign cs_rise  = synced[1] & ~prev_q[1];
   assign cs_fall  = ~synced[1] & prev_q[1];
   assign cs_low   = ~synced[1];
   assign si_s     = synced[2];
endmodule

// File: rtl/spi_nvm_wtimer.sv
module spi_nvm_wtimer #(
   parameter int TICKS = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(TICKS + 1);
   localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - ONE;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= LOAD;
      end
   end
endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
   parameter int         ADDR_W = 9,
   parameter int         PAGE_W = 4,
   parameter logic [7:0] INIT   = 8'hFF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [7:0]                  rd_data,
   input  logic                        commit,
   input  logic                        lock,
   input  logic [ADDR_W-PAGE_W-1:0]    page,
   input  logic [(8<<PAGE_W)-1:0]      wdata,
   input  logic [(1<<PAGE_W)-1:0]      wmask
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PB    = 1 << PAGE_W;

   logic [7:0] mem_q [DEPTH];

   assign rd_data = mem_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
      end else if (commit && !lock) begin
         for (int i = 0; i < PB; i++)
            if (wmask[i]) mem_q[{page, PAGE_W'(i)}] <= wdata[i*8 +: 8];
      end
   end
endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl #(
   parameter int         PAGE_W      = 4,
   parameter int         WRITE_TICKS = 20000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ERASED      = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_si,
   output logic       spi_so,
   input  logic       wp_n,
   output logic [1:0] wdt_sel
);
   import spi_nvm_pkg::*;

   localparam int ADDR_W     = NVM_ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int PAGE_IDX_W = ADDR_W - PAGE_W;
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [PAGE_W-1:0] OFF_ONE  = PAGE_W'(1);

   if (PAGE_W < 1 || PAGE_W > 7) begin : g_bad_page
      $error("PAGE_W must lie in 1..7");
   end
   if (WRITE_TICKS < 1) begin : g_bad_ticks
      $error("WRITE_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic sck_rise, sck_fall, cs_rise, cs_fall, cs_low, si_s;
   logic busy, done, start_wr;

   phase_e              phase_q;
   logic [7:0]          opc_q;
   logic [2:0]          bit_cnt_q;
   logic [6:0]          sreg_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [PAGE_IDX_W-1:0] page_q;
   logic [7:0]          out_ld_q, out_sh_q;
   logic                so_q;
   logic                wel_q, have_data_q, sr_got_q, pend_sr_q;
   logic [1:0]          bp_q, wdt_q;
   logic [3:0]          sr_new_q;
   logic [7:0]          wbuf_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0]   wmask_q;
   logic [8*PAGE_BYTES-1:0] wbuf_flat;

   logic [7:0]        rx_byte, status, rd_data;
   logic [ADDR_W-1:0] rd_addr;
   logic              byte_done, lock_page;

   spi_nvm_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
      .cs_fall(cs_fall), .cs_low(cs_low), .si_s(si_s));

   spi_nvm_wtimer #(.TICKS(WRITE_TICKS)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(start_wr), .busy(busy), .done(done));

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pack
      assign wbuf_flat[g*8 +: 8] = wbuf_q[g];
   end

   assign lock_page = region_locked(page_q[PAGE_IDX_W-1 -: 2], bp_q);

   spi_nvm_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .INIT(ERASED)) i_array (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .commit(done && !pend_sr_q), .lock(lock_page), .page(page_q),
      .wdata(wbuf_flat), .wmask(wmask_q));

   assign rx_byte   = {sreg_q, si_s};
   assign byte_done = cs_low && sck_rise && (bit_cnt_q == 3'd7);
   assign status    = {2'b00, wdt_q, bp_q, wel_q, busy};
   assign rd_addr   = (phase_q == PH_ADDR) ? {opc_q[3], rx_byte} : addr_q;
   assign start_wr  = cs_rise && (bit_cnt_q == 3'd0) && wel_q && wp_n && !busy &&
                      ((phase_q == PH_WDATA && have_data_q) || sr_got_q);
   assign spi_so    = so_q;
   assign wdt_sel   = wdt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         opc_q       <= '0;
         bit_cnt_q   <= '0;
         sreg_q      <= '0;
         addr_q      <= '0;
         page_q      <= '0;
         out_ld_q    <= '0;
         out_sh_q    <= '0;
         so_q        <= 1'b0;
         wel_q       <= 1'b0;
         have_data_q <= 1'b0;
         sr_got_q    <= 1'b0;
         pend_sr_q   <= 1'b0;
         bp_q        <= '0;
         wdt_q       <= '0;
         sr_new_q    <= '0;
         wmask_q     <= '0;
         for (int i = 0; i < PAGE_BYTES; i++) wbuf_q[i] <= '0;
      end else begin
         if (cs_fall) begin
            phase_q     <= PH_OPCODE;
            bit_cnt_q   <= '0;
            out_ld_q    <= '0;
            so_q        <= 1'b0;
            have_data_q <= 1'b0;
            sr_got_q    <= 1'b0;
         end else if (cs_low && sck_rise) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
            sreg_q    <= rx_byte[6:0];
            if (byte_done) begin
               case (phase_q)
                  PH_OPCODE: begin
                     opc_q <= rx_byte;
                     if (busy && rx_byte != CMD_STAT_RD) begin
                        phase_q <= PH_IDLE;
                     end else if (rx_byte == CMD_LATCH_SET) begin
                        wel_q <= 1'b1;  phase_q <= PH_IDLE;
                     end else if (rx_byte == CMD_LATCH_CLR) begin
                        wel_q <= 1'b0;  phase_q <= PH_IDLE;
                     end else if (rx_byte == CMD_STAT_RD) begin
                        out_ld_q <= status;  phase_q <= PH_STATUS;
                     end else if (rx_byte == CMD_STAT_WR) begin
                        phase_q <= PH_SRDATA;
                     end else if (cmd_is_read(rx_byte) || cmd_is_write(rx_byte)) begin
                        phase_q <= PH_ADDR;
                     end else begin
                        phase_q <= PH_IDLE;
                     end
                  end
                  PH_ADDR: begin
                     if (cmd_is_read(opc_q)) begin
                        out_ld_q <= rd_data;
                        addr_q   <= rd_addr + ADDR_ONE;
                        phase_q  <= PH_RDATA;
                     end else begin
                        addr_q   <= rd_addr;
                        page_q   <= rd_addr[ADDR_W-1:PAGE_W];
                        wmask_q  <= '0;
                        phase_q  <= PH_WDATA;
                     end
                  end
                  PH_RDATA: begin
                     out_ld_q <= rd_data;
                     addr_q   <= addr_q + ADDR_ONE;
                  end
                  PH_STATUS: out_ld_q <= status;
                  PH_WDATA: begin
                     wbuf_q[addr_q[PAGE_W-1:0]]  <= rx_byte;
                     wmask_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                     have_data_q                 <= 1'b1;
                     addr_q[PAGE_W-1:0]          <= addr_q[PAGE_W-1:0] + OFF_ONE;
                  end
                  PH_SRDATA: begin
                     sr_new_q <= rx_byte[5:2];
                     sr_got_q <= 1'b1;
                     phase_q  <= PH_IDLE;
                  end
                  default: ;
               endcase
            end
         end

         if (cs_low && sck_fall) begin
            if (bit_cnt_q == 3'd0) begin
               so_q     <= out_ld_q[7];
               out_sh_q <= {out_ld_q[6:0], 1'b0};
            end else begin
               so_q     <= out_sh_q[7];
               out_sh_q <= {out_sh_q[6:0], 1'b0};
            end
         end

         if (start_wr) pend_sr_q <= sr_got_q;

         if (done) begin
            wel_q <= 1'b0;
            if (pend_sr_q) begin
               bp_q  <= sr_new_q[1:0];
               wdt_q <= sr_new_q[3:2];
            end
         end
      end
   end
endmodule

// File: rtl/spi_nvm_ctrl_chk.sv
module spi_nvm_ctrl_chk #(
   parameter int TICKS = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wip,
   input logic       wel,
   input logic       wp_n,
   input logic [1:0] bp,
   input logic [1:0] wdt_sel,
   input logic       so,
   input logic       sck_fall,
   input logic       cs_fall
);
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   hi_cnt <= 0;
      else if (wip) hi_cnt <= hi_cnt + 1;
      else          hi_cnt <= 0;

   assert_busy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> (hi_cnt == TICKS));

   assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> (hi_cnt < TICKS));

   assert_start_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> ($past(wel) && $past(wp_n)));

   assert_latch_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);

   assert_wdt_only_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(wip) |-> $stable(wdt_sel));

   assert_lock_only_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(wip) |-> $stable(bp));

   assert_so_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(so) |-> $past(sck_fall || cs_fall));
endmodule

bind spi_nvm_ctrl spi_nvm_ctrl_chk #(.TICKS(WRITE_TICKS)) i_chk (
   .clk(clk), .rst_n(rst_n), .wip(busy), .wel(wel_q), .wp_n(wp_n),
   .bp(bp_q), .wdt_sel(wdt_sel), .so(spi_so), .sck_fall(sck_fall),
   .cs_fall(cs_fall));

// File: tb/test_spi_nvm_ctrl.sv
`timescale 1ns/1ps
module test_spi_nvm_ctrl;
   localparam int  TICKS = 1500;
   localparam time HALF  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
   logic so;
   logic [1:0] wdt_sel;
   logic mode3 = 1'b0;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   spi_nvm_ctrl #(.WRITE_TICKS(TICKS)) i_spi_nvm_ctrl (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_so(so), .wp_n(wp_n), .wdt_sel(wdt_sel));

   // {address[8:0], data[7:0]}
   localparam logic [16:0] VEC [6] = '{
      {9'h000, 8'h5A}, {9'h001, 8'hC3}, {9'h0FF, 8'h12},
      {9'h100, 8'hE7}, {9'h1FF, 8'h81}, {9'h15B, 8'h3C}};

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         if (mode3) sck = 1'b0;
         si = tx[i];
         #(HALF);
         rx[i] = so;
         sck = 1'b1;
         #(HALF);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic bits(input logic [7:0] tx, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         if (mode3) sck = 1'b0;
         si = tx[i];
         #(HALF);
         sck = 1'b1;
         #(HALF);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic cs_on();
      sck = mode3;
      #(HALF);
      cs_n = 1'b0;
      #(HALF);
   endtask

   task automatic cs_off();
      #(HALF);
      cs_n = 1'b1;
      #(2*HALF);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] rx;
      cs_on(); xfer(op, rx); cs_off();
   endtask

   task automatic rdsr(output logic [7:0] st);
      logic [7:0] rx;
      cs_on(); xfer(8'h05, rx); xfer(8'h00, st); cs_off();
   endtask

   task automatic wait_ready();
      logic [7:0] st;
      for (int k = 0; k < 40; k++) begin
         rdsr(st);
         if (!st[0]) break;
      end
   endtask

   task automatic mem_write1(input logic [8:0] a, input logic [7:0] d);
      logic [7:0] rx;
      cmd1(8'h06);
      cs_on();
      xfer({4'h0, a[8], 3'b010}, rx); xfer(a[7:0], rx); xfer(d, rx);
      cs_off();
   endtask

   task automatic mem_read1(input logic [8:0] a, output logic [7:0] d);
      logic [7:0] rx;
      cs_on();
      xfer({4'h0, a[8], 3'b011}, rx); xfer(a[7:0], rx); xfer(8'h00, d);
      cs_off();
   endtask

   task automatic stat_write(input logic [7:0] v);
      logic [7:0] rx;
      cmd1(8'h06);
      cs_on(); xfer(8'h01, rx); xfer(v, rx); cs_off();
      wait_ready();
   endtask

   initial begin
      #(4 * 190000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] st, d, rx;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Reset state (R10)
      rdsr(st);            check8("R10 reset status", st, 8'h00);
      check8("R10 reset wdt_sel", {6'h0, wdt_sel}, 8'h00);
      mem_read1(9'h000, d); check8("R10 erased array", d, 8'hFF);

      // Latch set/clear (R2), status layout (R3)
      cmd1(8'h06); rdsr(st); check8("R2 R3 latch set", st, 8'h02);
      cmd1(8'h04); rdsr(st); check8("R2 latch clear", st, 8'h00);

      // Table of single-byte writes then readback (R4 R5 R6)
      foreach (VEC[v]) begin
         mem_write1(VEC[v][16:8], VEC[v][7:0]);
         wait_ready();
         mem_read1(VEC[v][16:8], d);
         check8("R4 R6 table readback", d, VEC[v][7:0]);
      end

      // Sequential read wraps at the top of the array (R4)
      cs_on();
      xfer(8'h0B, rx); xfer(8'hFF, rx); xfer(8'h00, d);
      check8("R4 read at 0x1FF", d, 8'h81);
      xfer(8'h00, d);
      check8("R4 wrap to 0x000", d, 8'h5A);
      cs_off();

      // Mode 3 read and status (R1 R3)
      mode3 = 1'b1;
      mem_read1(9'h100, d); check8("R1 mode 3 read", d, 8'hE7);
      cs_on(); xfer(8'h05, rx); xfer(8'h00, st); xfer(8'h00, d); cs_off();
      check8("R1 R3 mode 3 repeated status", d, 8'h00);
      mode3 = 1'b0;

      // 18-byte page write starting at offset 14 (R5 R6 R11)
      cmd1(8'h06);
      cs_on();
      xfer(8'h02, rx); xfer(8'h2E, rx);
      for (int i = 0; i < 18; i++) xfer(8'hA0 + 8'(i), rx);
      cs_off();
      rdsr(st); check8("R6 busy after release", st, 8'h03);
      mem_read1(9'h020, d); check8("R11 read ignored while busy", d, 8'h00);
      wait_ready();
      rdsr(st); check8("R10 latch cleared at end", st, 8'h00);
      cs_on();
      xfer(8'h03, rx); xfer(8'h20, rx);
      for (int i = 0; i < 16; i++) begin
         xfer(8'h00, d);
         if (i < 14) check8("R5 page wrap body", d, 8'hA0 + 8'(i + 2));
         else        check8("R5 page wrap overwrite", d, 8'hA0 + 8'(i + 2));
      end
      cs_off();

      // Partial byte aborts the write (R12)
      cmd1(8'h06);
      cs_on(); xfer(8'h02, rx); xfer(8'h40, rx); xfer(8'h77, rx); bits(8'h55, 3); cs_off();
      rdsr(st); check8("R12 no cycle after abort", st, 8'h02);
      mem_read1(9'h040, d); check8("R12 data unchanged", d, 8'hFF);

      // Write-protect pin and missing latch (R7)
      wp_n = 1'b0;
      mem_write1(9'h050, 8'h11);
      rdsr(st); check8("R7 wp blocks cycle", st, 8'h02);
      mem_read1(9'h050, d); check8("R7 wp keeps data", d, 8'hFF);
      wp_n = 1'b1;
      cmd1(8'h04);
      cs_on(); xfer(8'h02, rx); xfer(8'h50, rx); xfer(8'h11, rx); cs_off();
      rdsr(st); check8("R7 no latch no cycle", st, 8'h00);
      mem_read1(9'h050, d); check8("R7 no latch keeps data", d, 8'hFF);

      // Status write (R9) then region locks (R8)
      stat_write(8'h34);
      rdsr(st); check8("R9 status loaded", st, 8'h34);
      check8("R9 wdt_sel port", {6'h0, wdt_sel}, 8'h03);
      mem_write1(9'h180, 8'h99); wait_ready();
      mem_read1(9'h180, d); check8("R8 quarter locked", d, 8'hFF);
      mem_write1(9'h17F, 8'h66); wait_ready();
      mem_read1(9'h17F, d); check8("R8 below quarter open", d, 8'h66);
      stat_write(8'h08);
      mem_write1(9'h100, 8'h55); wait_ready();
      mem_read1(9'h100, d); check8("R8 half locked", d, 8'hE7);
      mem_write1(9'h0F0, 8'h44); wait_ready();
      mem_read1(9'h0F0, d); check8("R8 below half open", d, 8'h44);
      stat_write(8'h0C);
      mem_write1(9'h000, 8'h22); wait_ready();
      mem_read1(9'h000, d); check8("R8 all locked", d, 8'h5A);
      stat_write(8'h20);
      rdsr(st); check8("R9 unlock and interval 2", st, 8'h20);
      check8("R9 wdt_sel follows", {6'h0, wdt_sel}, 8'h02);

      // Reset in mid-run (R10)
      @(negedge clk); rst_n = 1'b0;
      repeat (4) @(negedge clk); rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check8("R10 wdt_sel after reset", {6'h0, wdt_sel}, 8'h00);
      rdsr(st); check8("R10 status after reset", st, 8'h00);
      mem_read1(9'h001, d); check8("R10 array after reset", d, 8'hFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule